// File: doc/BRIEF.md
# Received-Frame Dispatch and Error Sequencer

This block is the port-level control sequencer of a serial storage host controller. It takes one received frame at a time. The frame is either one of several control-frame kinds or a data frame. Each frame is handled in three steps. First the block pulls the frame out of the receive buffer. Then it judges the error flags reported by the unit that parsed the frame. Finally it either accepts the frame with a positive acknowledge or enters a fatal or non-fatal error path. Frames that are unknown or merely ignored, such as those arriving during a loopback test, still map to a control kind. They are still pulled out so that the buffer drains.

The block produces one action per clock as a one-hot pulse vector. Two actions wait for the unit that serves them to answer with a done pulse: pulling a frame and aborting the DMA command. Any fatal error parks the sequencer in one hold state until software clears the port start bit. A stop sequence then releases the link, clears the command state and halts until the start bit is set again. Every error entry issues a negative-acknowledge request, even if the link layer may already have answered on its own. The link discards requests it is not waiting for, so a surplus one does no harm.

Top module: `frx_rx_seq`

## Requirements
- R1: While reset is held, `act_o` is all zero. On the first cycle after reset is released, `act_o` is also all zero: the sequencer spends that cycle in a no-operation start step before it reaches idle.
- R2: `act_o` has at most one bit set in any cycle, and no action bit stays high for two cycles in a row. The bit positions are: 0 pull frame, 1 positive ack, 2 negative ack, 3 fatal interrupt status, 4 non-fatal interrupt status, 5 task-file interrupt status, 6 command-issue bit 0 clear, 7 DMA abort, 8 run-flag clear, 9 transfer-counter clear.
- R3: In idle with the start bit set, a frame request sampled at a clock edge gives a pull-frame pulse in the next cycle. `kind_o` shows the served frame's kind at that pulse and stays stable until the frame is finished. Control kinds are numbered 0 to NUM_CTL-1, and the lowest-numbered pending request wins. The data frame is kind NUM_CTL.
- R4: After a pull-frame pulse the sequencer issues no action until `done_i` is sampled high. A `done_i` sampled in the pulse cycle itself is not counted. The error flags are sampled at the clock edge after the one that sampled `done_i`, and the outcome action appears in the cycle after that.
- R5: For a control frame the plain error flag wins and selects the non-fatal path. Otherwise the fatal flag selects the fatal path. Otherwise a positive ack is issued and the sequencer returns to idle. The extra-data flag is ignored for control frames.
- R6: For a data frame, the plain error flag or the fatal flag selects the fatal path. Otherwise the extra-data flag selects the non-fatal path. Otherwise the frame is positively acknowledged.
- R7: The fatal path issues a negative ack, then the fatal interrupt status in the next cycle, and then holds. While it holds, no action is issued and frame requests are not served, until the start bit is sampled low.
- R8: The non-fatal path issues a negative ack, then the non-fatal interrupt status in the next cycle, and then returns to idle, where the next request is served.
- R9: A task-file error request served in idle issues only the task-file interrupt status, with no negative ack, and then enters the fatal hold of R7.
- R10: When the start bit is sampled low in idle or in the fatal hold, the block issues on consecutive cycles: negative ack, command-issue clear, DMA abort. It then waits for `done_i`, after which it issues run-flag clear and transfer-counter clear on consecutive cycles.
- R11: After the stop sequence the block stays halted with no actions, and ignores frame requests, until the start bit is sampled high. It then returns to idle.
- R12: Idle priority, from highest to lowest: start bit low, task-file error request, data-frame request, control-frame requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Port start bit set by software |
| req_ctl_i | input | NUM_CTL | Start requests, one per control-frame kind |
| req_data_i | input | 1 | Start request for a received data frame |
| req_tferr_i | input | 1 | Task-file fatal error request |
| done_i | input | 1 | Completion pulse from the unit serving a waiting action |
| err_i | input | 1 | Plain error flag of the pulled frame |
| ferr_i | input | 1 | Fatal error flag of the pulled frame |
| extra_i | input | 1 | Extra-data flag of a data frame |
| act_o | output | 10 | One-hot action pulses (bit map in R2) |
| kind_o | output | $clog2(NUM_CTL+1) | Kind of the frame being served |

## Verification
Every result has a fixed cycle count, measured from the edge that samples its trigger. A frame request gives the pull pulse one cycle later. The outcome action comes two cycles after the edge that sees `done_i`, and each later step of a path follows one cycle after the step before it. The bench drives inputs and reads `act_o` on the falling edge. It walks the expected action list one cycle at a time and checks the cycles between actions for silence as well. This covers the waits of arbitrary length before `done_i`, the fatal hold and the halt, where stray requests are applied on purpose.

// File: rtl/frx_pkg.sv
package frx_pkg;

   localparam int ACT_W        = 10;
   localparam int A_PULL       = 0;
   localparam int A_POS_ACK    = 1;
   localparam int A_NEG_ACK    = 2;
   localparam int A_IRQ_FATAL  = 3;
   localparam int A_IRQ_SOFT   = 4;
   localparam int A_IRQ_TFILE  = 5;
   localparam int A_CI_CLR     = 6;
   localparam int A_DMA_ABORT  = 7;
   localparam int A_RUN_CLR    = 8;
   localparam int A_XCNT_CLR   = 9;

   typedef enum logic [4:0] {
      ST_POR,
      ST_IDLE,
      ST_PULL,
      ST_PULL_WAIT,
      ST_JUDGE,
      ST_ACCEPT,
      ST_SOFT_NAK,
      ST_SOFT_IRQ,
      ST_HARD_NAK,
      ST_HARD_IRQ,
      ST_TFILE_IRQ,
      ST_FAT_HOLD,
      ST_STP_NAK,
      ST_STP_CI,
      ST_STP_DMA,
      ST_STP_DMAW,
      ST_STP_RUN,
      ST_STP_XCNT,
      ST_HALT
   } seq_st_t;

   typedef enum logic [1:0] {
      VD_ACCEPT,
      VD_SOFT,
      VD_HARD
   } verdict_t;

endpackage

// File: rtl/frx_req_pick.sv
module frx_req_pick #(
   parameter int N         = 6,
   parameter bit LOW_FIRST = 1'b1,
   localparam int IW       = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req_i,
   output logic          hit_o,
   output logic [IW-1:0] idx_o
);

   generate
      if (N < 1) begin : g_bad_n
         $error("frx_req_pick: N must be at least 1");
      end

      if (LOW_FIRST) begin : g_low
         always_comb begin
            idx_o = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req_i[i]) idx_o = IW'(i);
            end
         end
      end else begin : g_high
         always_comb begin
            idx_o = '0;
            for (int i = 0; i < N; i++) begin
               if (req_i[i]) idx_o = IW'(i);
            end
         end
      end
   endgenerate

   assign hit_o = |req_i;

endmodule

// File: rtl/frx_err_judge.sv
module frx_err_judge
   import frx_pkg::*;
(
   input  logic     is_data_i,
   input  logic     err_i,
   input  logic     ferr_i,
   input  logic     extra_i,
   output verdict_t verdict_o
);

   always_comb begin
      if (is_data_i) begin
         if (err_i || ferr_i)  verdict_o = VD_HARD;
         else if (extra_i)     verdict_o = VD_SOFT;
         else                  verdict_o = VD_ACCEPT;
      end else begin
         if (err_i)            verdict_o = VD_SOFT;
         else if (ferr_i)      verdict_o = VD_HARD;
         else                  verdict_o = VD_ACCEPT;
      end
   end

endmodule

// File: rtl/frx_act_decode.sv
module frx_act_decode
   import frx_pkg::*;
(
   input  seq_st_t          st_i,
   output logic [ACT_W-1:0] act_o
);

   always_comb begin
      act_o = '0;
      unique case (st_i)
         ST_PULL:      act_o[A_PULL]      = 1'b1;
         ST_ACCEPT:    act_o[A_POS_ACK]   = 1'b1;
         ST_SOFT_NAK,
         ST_HARD_NAK,
         ST_STP_NAK:   act_o[A_NEG_ACK]   = 1'b1;
         ST_HARD_IRQ:  act_o[A_IRQ_FATAL] = 1'b1;
         ST_SOFT_IRQ:  act_o[A_IRQ_SOFT]  = 1'b1;
         ST_TFILE_IRQ: act_o[A_IRQ_TFILE] = 1'b1;
         ST_STP_CI:    act_o[A_CI_CLR]    = 1'b1;
         ST_STP_DMA:   act_o[A_DMA_ABORT] = 1'b1;
         ST_STP_RUN:   act_o[A_RUN_CLR]   = 1'b1;
         ST_STP_XCNT:  act_o[A_XCNT_CLR]  = 1'b1;
         default:      act_o              = '0;
      endcase
   end

endmodule

// File: rtl/frx_rx_seq.sv
module frx_rx_seq
   import frx_pkg::*;
#(
   parameter int NUM_CTL   = 6,
   parameter bit LOW_FIRST = 1'b1,
   localparam int PW       = (NUM_CTL > 1) ? $clog2(NUM_CTL) : 1,
   localparam int KW       = $clog2(NUM_CTL + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_i,
   input  logic [NUM_CTL-1:0] req_ctl_i,
   input  logic               req_data_i,
   input  logic               req_tferr_i,
   input  logic               done_i,
   input  logic               err_i,
   input  logic               ferr_i,
   input  logic               extra_i,
   output logic [ACT_W-1:0]   act_o,
   output logic [KW-1:0]      kind_o
);

   localparam logic [KW-1:0] DATA_KIND = KW'(NUM_CTL);

   generate
      if (NUM_CTL < 1 || NUM_CTL > 64) begin : g_bad_cfg
         $error("frx_rx_seq: NUM_CTL out of range 1..64");
      end
   endgenerate

   seq_st_t        st_q, st_d;
   logic [KW-1:0]  kind_q, kind_d;
   logic           ctl_hit;
   logic [PW-1:0]  ctl_idx;
   logic           is_data;
   verdict_t       verdict;

   frx_req_pick #(.N(NUM_CTL), .LOW_FIRST(LOW_FIRST)) u_pick (
      .req_i (req_ctl_i),
      .hit_o (ctl_hit),
      .idx_o (ctl_idx)
   );

   assign is_data = (kind_q == DATA_KIND);

   frx_err_judge u_judge (
      .is_data_i (is_data),
      .err_i     (err_i),
      .ferr_i    (ferr_i),
      .extra_i   (extra_i),
      .verdict_o (verdict)
   );

   frx_act_decode u_dec (
      .st_i  (st_q),
      .act_o (act_o)
   );

   always_comb begin
      st_d   = st_q;
      kind_d = kind_q;
      unique case (st_q)
         ST_POR:       st_d = ST_IDLE;
         ST_IDLE: begin
            if (!run_i)              st_d = ST_STP_NAK;
            else if (req_tferr_i)    st_d = ST_TFILE_IRQ;
            else if (req_data_i) begin
               st_d   = ST_PULL;
               kind_d = DATA_KIND;
            end else if (ctl_hit) begin
               st_d   = ST_PULL;
               kind_d = KW'(ctl_idx);
            end
         end
         ST_PULL:      st_d = ST_PULL_WAIT;
         ST_PULL_WAIT: if (done_i) st_d = ST_JUDGE;
         ST_JUDGE: begin
            unique case (verdict)
               VD_SOFT: st_d = ST_SOFT_NAK;
               VD_HARD: st_d = ST_HARD_NAK;
               default: st_d = ST_ACCEPT;
            endcase
         end
         ST_ACCEPT:    st_d = ST_IDLE;
         ST_SOFT_NAK:  st_d = ST_SOFT_IRQ;
         ST_SOFT_IRQ:  st_d = ST_IDLE;
         ST_HARD_NAK:  st_d = ST_HARD_IRQ;
         ST_HARD_IRQ:  st_d = ST_FAT_HOLD;
         ST_TFILE_IRQ: st_d = ST_FAT_HOLD;
         ST_FAT_HOLD:  if (!run_i) st_d = ST_STP_NAK;
         ST_STP_NAK:   st_d = ST_STP_CI;
         ST_STP_CI:    st_d = ST_STP_DMA;
         ST_STP_DMA:   st_d = ST_STP_DMAW;
         ST_STP_DMAW:  if (done_i) st_d = ST_STP_RUN;
         ST_STP_RUN:   st_d = ST_STP_XCNT;
         ST_STP_XCNT:  st_d = ST_HALT;
         ST_HALT:      if (run_i) st_d = ST_IDLE;
         default:      st_d = ST_POR;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_POR;
         kind_q <= '0;
      end else begin
         st_q   <= st_d;
         kind_q <= kind_d;
      end
   end

   assign kind_o = kind_q;

   AST_ACT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(act_o)); // R2
   AST_PULL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      act_o[A_PULL] |=> !act_o[A_PULL]); // R2
   AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PULL_WAIT) |-> (act_o == '0)); // R4
   AST_KIND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PULL_WAIT) |-> $stable(kind_o)); // R3
   AST_FATAL_AFTER_NAK: assert property (@(posedge clk) disable iff (!rst_n)
      act_o[A_IRQ_FATAL] |-> $past(act_o[A_NEG_ACK])); // R7
   AST_SOFT_AFTER_NAK: assert property (@(posedge clk) disable iff (!rst_n)
      act_o[A_IRQ_SOFT] |-> $past(act_o[A_NEG_ACK])); // R8
   AST_TFILE_NO_NAK: assert property (@(posedge clk) disable iff (!rst_n)
      act_o[A_IRQ_TFILE] |-> !$past(act_o[A_NEG_ACK])); // R9
   AST_CI_AFTER_NAK: assert property (@(posedge clk) disable iff (!rst_n)
      act_o[A_CI_CLR] |-> $past(act_o[A_NEG_ACK])); // R10
   AST_XCNT_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      act_o[A_XCNT_CLR] |-> $past(act_o[A_RUN_CLR])); // R10
   AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HALT) |-> (act_o == '0)); // R11

endmodule

// File: tb/tb_frx_rx_seq.sv
`timescale 1ns/1ps
module tb_frx_rx_seq;

   localparam int NCTL = 6;
   localparam int KW   = 3;
   localparam int AW   = 10;
   // action bit map from R2
   localparam int B_PULL = 0, B_POS = 1, B_NAK = 2, B_IRQF = 3, B_IRQS = 4,
                  B_IRQT = 5, B_CI = 6, B_DMA = 7, B_RUN = 8, B_XCNT = 9;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            run_i = 1'b1;
   logic [NCTL-1:0] req_ctl_i = '0;
   logic            req_data_i = 1'b0, req_tferr_i = 1'b0, done_i = 1'b0;
   logic            err_i = 1'b0, ferr_i = 1'b0, extra_i = 1'b0;
   logic [AW-1:0]   act_o;
   logic [KW-1:0]   kind_o;

   int nchk = 0;
   int nfail = 0;

   always #2 clk = ~clk;

   frx_rx_seq #(.NUM_CTL(NCTL)) dut (
      .clk(clk), .rst_n(rst_n), .run_i(run_i), .req_ctl_i(req_ctl_i),
      .req_data_i(req_data_i), .req_tferr_i(req_tferr_i), .done_i(done_i),
      .err_i(err_i), .ferr_i(ferr_i), .extra_i(extra_i),
      .act_o(act_o), .kind_o(kind_o));

   function automatic logic [AW-1:0] bit_of(input int b);
      return AW'(1) << b;
   endfunction

   // 0 accept, 1 non-fatal, 2 fatal (R5, R6)
   function automatic int judge(input bit is_data, input bit e, input bit f, input bit x);
      if (is_data) return (e || f) ? 2 : (x ? 1 : 0);
      return e ? 1 : (f ? 2 : 0);
   endfunction

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input logic [AW-1:0] exp, input string tag);
      nchk++;
      if (act_o !== exp) begin
         nfail++;
         $display("FAIL %s act=%b expected=%b at %0t", tag, act_o, exp, $time);
      end
   endtask

   task automatic chk_kind(input int exp, input string tag);
      nchk++;
      if (kind_o !== KW'(exp)) begin
         nfail++;
         $display("FAIL %s kind=%0d expected=%0d", tag, kind_o, exp);
      end
   endtask

   // entered at a negedge with state idle or fatal hold
   task automatic stop_seq(input int dly);
      run_i = 1'b0;
      tick(); chk(bit_of(B_NAK),  "R10 stop nak");
      tick(); chk(bit_of(B_CI),   "R10 ci clear");
      tick(); chk(bit_of(B_DMA),  "R10 dma abort");
      tick(); chk('0,             "R10 dma wait");
      for (int i = 0; i < dly; i++) begin tick(); chk('0, "R10 dma wait"); end
      done_i = 1'b1;
      tick(); chk(bit_of(B_RUN),  "R10 run clear");
      done_i = 1'b0;
      tick(); chk(bit_of(B_XCNT), "R10 xcnt clear");
      tick(); chk('0,             "R11 halted");
      req_ctl_i = 6'b000001; req_data_i = 1'b1;
      tick(); chk('0,             "R11 request ignored in halt");
      req_ctl_i = '0; req_data_i = 1'b0;
      run_i = 1'b1;
      tick(); chk('0,             "R11 back to idle");
   endtask

   // kind < NCTL: control, kind == NCTL: data; entered at negedge in idle
   task automatic frame(input int kind, input bit e, input bit f, input bit x, input int dly);
      int v;
      if (kind == NCTL) req_data_i = 1'b1; else req_ctl_i = NCTL'(1) << kind;
      tick(); chk(bit_of(B_PULL), "R3 pull pulse"); chk_kind(kind, "R3 kind");
      req_ctl_i = '0; req_data_i = 1'b0;
      done_i = 1'b1;  // sampled in the pulse cycle: must not count (R4)
      tick(); chk('0, "R4 wait after pull");
      done_i = 1'b0;
      for (int i = 0; i < dly; i++) begin tick(); chk('0, "R4 waiting for done"); end
      done_i = 1'b1; err_i = e; ferr_i = f; extra_i = x;
      tick(); chk('0, "R4 judge cycle");
      done_i = 1'b0;
      tick();
      v = judge(kind == NCTL, e, f, x);
      err_i = 1'b0; ferr_i = 1'b0; extra_i = 1'b0;
      if (v == 0) begin
         chk(bit_of(B_POS), (kind == NCTL) ? "R6 accept" : "R5 accept");
         tick(); chk('0, "R5 idle after accept");
      end else if (v == 1) begin
         chk(bit_of(B_NAK), (kind == NCTL) ? "R6 soft nak" : "R5 soft nak");
         tick(); chk(bit_of(B_IRQS), "R8 soft irq");
         tick(); chk('0, "R8 idle");
      end else begin
         chk(bit_of(B_NAK), (kind == NCTL) ? "R6 hard nak" : "R5 hard nak");
         tick(); chk(bit_of(B_IRQF), "R7 fatal irq");
         tick(); chk('0, "R7 hold");
         req_ctl_i = 6'b000010;
         tick(); chk('0, "R7 request ignored in hold");
         req_ctl_i = '0;
         stop_seq(dly);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      nfail++;
      $display("FAIL watchdog expired act=%b expected=finished", act_o);
      summary();
   end

   initial begin
      void'($urandom(32'h1bad5eed));
      // R1 reset
      repeat (3) begin tick(); chk('0, "R1 in reset"); end
      rst_n = 1'b1;
      tick(); chk('0, "R1 first cycle after reset");

      // R3 lowest index wins
      req_ctl_i = 6'b010100;
      tick(); chk(bit_of(B_PULL), "R3 pull"); chk_kind(2, "R3 lowest kind");
      req_ctl_i = '0;
      tick(); chk('0, "R4 wait");
      done_i = 1'b1; tick(); done_i = 1'b0; chk('0, "R4 judge");
      tick(); chk(bit_of(B_POS), "R5 accept"); tick();

      // R12 data beats control
      req_ctl_i = 6'b000001; req_data_i = 1'b1;
      tick(); chk(bit_of(B_PULL), "R12 data first"); chk_kind(NCTL, "R12 data kind");
      req_ctl_i = '0; req_data_i = 1'b0;
      tick(); done_i = 1'b1; extra_i = 1'b1; tick(); done_i = 1'b0;
      tick(); extra_i = 1'b0; chk(bit_of(B_NAK), "R6 extra soft");
      tick(); chk(bit_of(B_IRQS), "R8 soft irq"); tick();

      // R5 extra ignored for control; R5 error beats fatal
      frame(3, 1'b0, 1'b0, 1'b1, 1);
      frame(1, 1'b1, 1'b1, 1'b0, 0);
      // R6 data with both error and extra: fatal
      frame(NCTL, 1'b1, 1'b0, 1'b1, 2);

      // R12 / R9 task-file beats data
      req_tferr_i = 1'b1; req_data_i = 1'b1;
      tick(); chk(bit_of(B_IRQT), "R9 taskfile irq only");
      req_tferr_i = 1'b0; req_data_i = 1'b0;
      tick(); chk('0, "R9 fatal hold");
      req_ctl_i = 6'b100000;
      tick(); chk('0, "R7 hold ignores request");
      req_ctl_i = '0;
      stop_seq(1);

      // R12 start bit low beats task-file
      req_tferr_i = 1'b1;
      stop_seq(0);
      req_tferr_i = 1'b0;

      // random mix
      for (int n = 0; n < 80; n++) begin
         int k  = $urandom_range(0, NCTL);
         bit e  = ($urandom_range(0, 3) == 0);
         bit f  = ($urandom_range(0, 3) == 0);
         bit x  = ($urandom_range(0, 3) == 0);
         frame(k, e, f, x, $urandom_range(0, 3));
      end
      summary();
   end

endmodule